// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Retransmit

This block is a first-in first-out store of 18-bit words whose write side and read side run on separate clocks. The read timing is chosen when master reset is released. In standard timing, a word leaves the store only when the reader asks for it. In fall-through timing, the oldest word moves onto the output by itself and stays there until the reader takes it. Two active-low pins change meaning with the timing. One pin reports empty in standard timing and output-valid in fall-through timing. The other pin reports full in standard timing and room-available in fall-through timing.

Three more active-low flags are produced in both timings: half-full, almost-empty and almost-full. The almost thresholds come in as offsets from a register block outside this one. A partial reset empties the store and keeps the timing selection. A retransmit pulse moves the read position back to the first memory location, so the data is read out again. Pointers cross between the clock domains in Gray code through two-flop synchronisers. Flags that concern writing are computed on the write clock, and flags that concern reading are computed on the read clock.

Top module: `dual_mode_fifo`

## Requirements
- R1: The level of `mode_fwft_i` at the rising edge of `rst_ni` selects the timing (0 standard, 1 fall-through). The selection holds until the next master reset and is not changed by a partial reset.
- R2: In standard timing, a read (`rd_en_i` high on a read-clock edge while words are stored) puts the oldest word on `dout_o` after that edge. Otherwise `dout_o` holds its value, and a newly written word never appears on its own.
- R3: In fall-through timing, a word written into an empty FIFO is on `dout_o`, with `empty_or_no` low, after the third read-clock edge that follows the write edge, and not after the second. Every read with `empty_or_no` low consumes the shown word and advances to the next one.
- R4: `empty_or_no` is low when the FIFO is empty (standard) or when a valid word is shown (fall-through). `full_ir_no` is low when the FIFO is full (standard) or when there is room for a write (fall-through).
- R5: Capacity is DEPTH words in standard timing and DEPTH+1 in fall-through timing, because the output stage holds one word. A write while full is ignored and overwrites nothing.
- R6: A read while nothing is available is ignored: `dout_o` does not change and no stored word is skipped.
- R7: `half_full_no` is low while the write-side memory count is greater than DEPTH/2.
- R8: `almost_empty_no` is low while the readable count (memory plus the shown word in fall-through timing) is at most `ae_off_i`.
- R9: `almost_full_no` is low while DEPTH minus the write-side memory count is at most `af_off_i`.
- R10: After master reset the FIFO is empty, `dout_o` is 0, and all flags show the empty state for the selected timing.
- R11: `prst_ni` held low across edges of both clocks empties the FIFO and returns the flags to the empty state.
- R12: `rt_ni` low on a read-clock edge moves the read position back to memory location 0. Later reads then return the words from the first one written since the last reset, provided that at most DEPTH words have been written since that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| prst_ni | input | 1 | Partial reset, synchronous in each domain, active low |
| mode_fwft_i | input | 1 | Timing select, captured at master reset release |
| wr_en_i | input | 1 | Write request |
| din_i | input | WORD_W | Write data |
| rd_en_i | input | 1 | Read request |
| rt_ni | input | 1 | Retransmit, active low |
| ae_off_i | input | $clog2(DEPTH)+1 | Almost-empty offset |
| af_off_i | input | $clog2(DEPTH)+1 | Almost-full offset |
| dout_o | output | WORD_W | Read data |
| empty_or_no | output | 1 | Empty (standard) / output valid (fall-through), active low |
| full_ir_no | output | 1 | Full (standard) / input ready (fall-through), active low |
| half_full_no | output | 1 | Half-full flag, active low |
| almost_empty_no | output | 1 | Almost-empty flag, active low |
| almost_full_no | output | 1 | Almost-full flag, active low |

## Verification
The bench checks the exact fall-through latency. A design with one synchroniser stage too many or too few shows the word one edge late or early. It fills the FIFO to its capacity in both timings and then writes more. A design that writes while full corrupts the oldest data, and one that ignores the output stage reports full one word too soon in fall-through timing. It reads while empty, which would repeat a word or skip one, and it places the almost-empty count exactly at the offset to catch an off-by-one compare. It also retransmits in both timings, which exposes a stale output word after the rewind, and changes the mode input during a partial reset to catch a mode that is re-latched.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  localparam int unsigned WORD_W = 18;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} rd_mode_e;
endpackage

// File: rtl/dmf_ram.sv
module dmf_ram #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          clr_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i)
    if (we_i) mem[waddr_i] <= wdata_i;

  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni)      rdata_o <= '0;
    else if (!clr_ni) rdata_o <= '0;
    else if (re_i)    rdata_o <= mem[raddr_i];
endmodule

// File: rtl/dmf_ptr_sync.sv
module dmf_ptr_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (!clr_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end

  for (genvar g = 0; g < W; g++) begin : g_g2b
    assign bin_o[g] = ^s2_q[W-1:g];
  end
endmodule

// File: rtl/dmf_wr_ctrl.sv
module dmf_wr_ctrl #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] rbin_i,
  input  logic [CW-1:0] af_off_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [CW-1:0] wgray_o,
  output logic          full_o,
  output logic          half_o,
  output logic          afull_o
);
  logic [CW-1:0] wptr_q, wptr_nxt, cnt, free;

  assign cnt      = wptr_q - rbin_i;
  assign free     = CW'(DEPTH) - cnt;
  assign full_o   = (cnt == CW'(DEPTH));
  assign half_o   = (cnt > CW'(DEPTH / 2));
  assign afull_o  = (free <= af_off_i);
  assign we_o     = wr_en_i & ~full_o;
  assign wptr_nxt = wptr_q + CW'(we_o);
  assign waddr_o  = wptr_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_o <= '0;
    end else if (!prst_ni) begin
      wptr_q  <= '0;
      wgray_o <= '0;
    end else begin
      wptr_q  <= wptr_nxt;
      wgray_o <= wptr_nxt ^ (wptr_nxt >> 1);
    end

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && prst_ni) |=> (wptr_q == $past(wptr_q)));

  assert_fill_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/dmf_rd_ctrl.sv
module dmf_rd_ctrl #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_i,
  input  logic          rd_en_i,
  input  logic          rt_ni,
  input  logic [CW-1:0] wbin_i,
  input  logic [CW-1:0] ae_off_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] rgray_o,
  output logic          mem_empty_o,
  output logic          valid_o,
  output logic          aempty_o
);
  logic [CW-1:0] rptr_q, rptr_nxt, mcnt;
  logic [CW:0]   vis_cnt;

  assign mcnt        = wbin_i - rptr_q;
  assign mem_empty_o = (mcnt == '0);
  assign raddr_o     = rptr_q[AW-1:0];
  assign vis_cnt     = {1'b0, mcnt} + (CW+1)'(fwft_i & valid_o);
  assign aempty_o    = (vis_cnt <= {1'b0, ae_off_i});

  always_comb begin
    re_o = 1'b0;
    if (rt_ni)
      re_o = fwft_i ? (~mem_empty_o & (~valid_o | rd_en_i))
                    : (rd_en_i & ~mem_empty_o);
    rptr_nxt = rptr_q + CW'(re_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_o <= '0;
      valid_o <= 1'b0;
    end else if (!prst_ni || !rt_ni) begin
      rptr_q  <= '0;
      rgray_o <= '0;
      valid_o <= 1'b0;
    end else begin
      rptr_q  <= rptr_nxt;
      rgray_o <= rptr_nxt ^ (rptr_nxt >> 1);
      valid_o <= fwft_i & (re_o | (valid_o & ~rd_en_i));
    end

  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_empty_o && rt_ni && prst_ni) |=> (rptr_q == $past(rptr_q)));

  assert_rewind_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rt_ni) |=> (rptr_q == '0));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned WORD_W = dmf_pkg::WORD_W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              prst_ni,
  input  logic              mode_fwft_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              rd_en_i,
  input  logic              rt_ni,
  input  logic [CW-1:0]     ae_off_i,
  input  logic [CW-1:0]     af_off_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              empty_or_no,
  output logic              full_ir_no,
  output logic              half_full_no,
  output logic              almost_empty_no,
  output logic              almost_full_no
);
  rd_mode_e      mode_q;
  logic          fwft;
  logic          we, re, full, half, afull, mem_empty, rd_valid, aempty;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] wgray, rgray, wbin_rs, rbin_ws;

  // captured at master reset release, static afterwards
  always_ff @(posedge rst_ni) mode_q <= rd_mode_e'(mode_fwft_i);
  assign fwft = (mode_q == MODE_FWFT);

  dmf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .prst_ni(prst_ni), .wr_en_i(wr_en_i),
    .rbin_i(rbin_ws), .af_off_i(af_off_i), .we_o(we), .waddr_o(waddr),
    .wgray_o(wgray), .full_o(full), .half_o(half), .afull_o(afull));

  dmf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .prst_ni(prst_ni), .fwft_i(fwft),
    .rd_en_i(rd_en_i), .rt_ni(rt_ni), .wbin_i(wbin_rs), .ae_off_i(ae_off_i),
    .re_o(re), .raddr_o(raddr), .rgray_o(rgray), .mem_empty_o(mem_empty),
    .valid_o(rd_valid), .aempty_o(aempty));

  dmf_ptr_sync #(.W(CW)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .clr_ni(prst_ni), .gray_i(wgray), .bin_o(wbin_rs));

  dmf_ptr_sync #(.W(CW)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .clr_ni(prst_ni), .gray_i(rgray), .bin_o(rbin_ws));

  dmf_ram #(.W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(din_i),
    .rclk_i(rclk_i), .rst_ni(rst_ni), .clr_ni(prst_ni), .re_i(re),
    .raddr_i(raddr), .rdata_o(dout_o));

  assign empty_or_no     = fwft ? ~rd_valid : ~mem_empty;
  assign full_ir_no      = fwft ? full : ~full;
  assign half_full_no    = ~half;
  assign almost_empty_no = ~aempty;
  assign almost_full_no  = ~afull;

  assert_std_hold_R2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft && !rd_en_i && prst_ni) |=> $stable(dout_o));

  assert_fwft_hold_R3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft && rd_valid && !rd_en_i && rt_ni && prst_ni) |=> $stable(dout_o));
endmodule

// File: tb/dual_mode_fifo_test.sv
module dual_mode_fifo_test;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int AE    = 3;
  localparam int AF    = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_ni = 1'b0, prst_ni = 1'b1, mode = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, rt_ni = 1'b1;
  logic [17:0]   din = '0;
  logic [17:0]   dout;
  logic          ef, ff, hf, ae, af;

  dual_mode_fifo #(.DEPTH(DEPTH)) uut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni), .prst_ni(prst_ni),
    .mode_fwft_i(mode), .wr_en_i(wr_en), .din_i(din), .rd_en_i(rd_en),
    .rt_ni(rt_ni), .ae_off_i(CW'(AE)), .af_off_i(CW'(AF)), .dout_o(dout),
    .empty_or_no(ef), .full_ir_no(ff), .half_full_no(hf),
    .almost_empty_no(ae), .almost_full_no(af));

  logic [17:0] hist[$];
  int  rd_idx = 0;
  bit  fwft_m = 0;
  int  n_tests = 0, n_fail = 0;
  bit  done = 0;

  function automatic int total();
    return hist.size() - rd_idx;
  endfunction

  function automatic int wcnt();
    int t = total();
    return (fwft_m && t > 0) ? t - 1 : t;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) tick();
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    int t = total();
    int w = wcnt();
    chk(req, "empty_or_no", 32'(ef), fwft_m ? (t > 0 ? 0 : 1) : (t == 0 ? 0 : 1));
    chk(req, "full_ir_no", 32'(ff), fwft_m ? (w == DEPTH ? 1 : 0) : (w == DEPTH ? 0 : 1));
    chk(req, "half_full_no", 32'(hf), (w > DEPTH / 2) ? 0 : 1);
    chk(req, "almost_empty_no", 32'(ae), (t <= AE) ? 0 : 1);
    chk(req, "almost_full_no", 32'(af), (DEPTH - w <= AF) ? 0 : 1);
  endtask

  task automatic wr(input logic [17:0] d);
    din = d;
    wr_en = 1'b1;
    if (wcnt() < DEPTH) hist.push_back(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_std(input string req);
    logic [17:0] prev = dout;
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    if (total() > 0) begin
      chk(req, "dout", 32'(dout), 32'(hist[rd_idx]));
      rd_idx++;
    end else begin
      chk(req, "dout unchanged", 32'(dout), 32'(prev));
    end
  endtask

  task automatic rd_fwft(input string req);
    chk(req, "output ready", 32'(ef), 0);
    chk(req, "dout", 32'(dout), 32'(hist[rd_idx]));
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    rd_idx++;
  endtask

  task automatic mreset(input logic m);
    rst_ni = 1'b0;
    mode = m;
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
    mode = ~m;
    hist.delete();
    rd_idx = 0;
    fwft_m = m;
  endtask

  task automatic preset();
    mode = ~fwft_m;
    prst_ni = 1'b0;
    repeat (2) tick();
    prst_ni = 1'b1;
    hist.delete();
    rd_idx = 0;
    tick();
  endtask

  task automatic retransmit();
    rt_ni = 1'b0;
    tick();
    rt_ni = 1'b1;
    rd_idx = 0;
  endtask

  initial begin
    #(100000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [17:0] keep;
    tick();
    // ---------------- standard timing ----------------
    mreset(1'b0);
    chk("R10", "dout after reset", 32'(dout), 0);
    check_flags("R10");

    wr(18'h00A01);
    settle();
    chk("R2", "no spontaneous word", 32'(dout), 0);
    check_flags("R4");

    for (int i = 1; i < DEPTH; i++) wr(18'h00A00 + 18'(i + 1));
    settle();
    check_flags("R5");
    wr(18'h3FFFF);
    wr(18'h3FFFE);
    settle();
    check_flags("R5");

    for (int i = 0; i < 5; i++) rd_std("R2");
    settle();
    check_flags("R9");

    keep = dout;
    retransmit();
    chk("R12", "dout held on rewind", 32'(dout), 32'(keep));
    settle();
    check_flags("R12");
    for (int i = 0; i < DEPTH; i++) rd_std("R12");
    settle();
    check_flags("R7");
    rd_std("R6");
    rd_std("R6");
    settle();
    check_flags("R6");

    for (int i = 0; i < AE; i++) wr(18'h00B00 + 18'(i));
    settle();
    check_flags("R8");
    wr(18'h00B10);
    settle();
    check_flags("R8");
    for (int i = 0; i < 6; i++) wr(18'h00B20 + 18'(i));
    settle();
    check_flags("R7");

    preset();
    settle();
    check_flags("R11");
    keep = dout;
    wr(18'h00C01);
    settle();
    chk("R1", "std kept after partial reset", 32'(dout), 32'(keep));
    rd_std("R11");

    // ---------------- fall-through timing ----------------
    mreset(1'b1);
    check_flags("R10");
    din = 18'h01234;
    wr_en = 1'b1;
    hist.push_back(din);
    tick();
    wr_en = 1'b0;
    tick();
    tick();
    chk("R3", "not ready after second edge", 32'(ef), 1);
    tick();
    chk("R3", "ready after third edge", 32'(ef), 0);
    chk("R3", "fallen-through word", 32'(dout), 32'h01234);
    rd_fwft("R3");
    settle();
    check_flags("R4");

    preset();
    for (int i = 0; i < 8; i++) wr(18'h02000 + 18'(i));
    settle();
    check_flags("R3");
    for (int i = 0; i < 4; i++) rd_fwft("R3");
    retransmit();
    settle();
    check_flags("R12");
    for (int i = 0; i < 8; i++) rd_fwft("R12");
    settle();
    check_flags("R6");

    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    settle();
    check_flags("R6");
    wr(18'h02A5A);
    settle();
    rd_fwft("R6");

    preset();
    for (int i = 0; i < DEPTH + 1; i++) wr(18'h03000 + 18'(i));
    settle();
    check_flags("R5");
    wr(18'h3DEAD);
    settle();
    check_flags("R5");
    for (int i = 0; i < DEPTH + 1; i++) rd_fwft("R5");
    settle();
    check_flags("R8");

    preset();
    wr(18'h04444);
    settle();
    chk("R11", "fall-through kept after partial reset", 32'(ef), 0);
    chk("R11", "dout", 32'(dout), 32'h04444);

    // back to standard: pin meaning follows new selection
    mreset(1'b0);
    check_flags("R1");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule